// File: doc/BRIEF.md
# Zeroing Idiom Detector and Renamer

This decode-stage block accepts a stream of two-byte register-to-register instructions: an opcode byte, then a register byte whose top two bits give the addressing mode and whose lower six bits hold two 3-bit register numbers. It spots the common way of clearing a register, an exclusive-or or a subtract of a register with itself. For such an idiom the destination is pointed at a shared, always-zero physical register in the rename table. The flags that the operation would produce are generated on the spot, and the instruction is marked as needing no execution slot.

Every other instruction is passed on with a freshly allocated physical destination and a request for execution. A move of an immediate zero is one of these. Results leave through a single registered output stage with a valid/ready handshake. A combinational read port exposes the current mapping of any architectural register.

Top module: `zidiom_rename`

## Requirements
- R1: An instruction with opcode 8'h31 or 8'h33, mode bits [7:6] equal to 2'b11 and bits [5:3] equal to bits [2:0] is reported as an idiom (`out_is_idiom`=1).
- R2: An instruction with opcode 8'h29 or 8'h2B, mode 2'b11 and equal register fields is also reported as an idiom.
- R3: For an idiom, `out_phys_dst` equals the zero register (index NUM_PHYS-1, 15 by default), `out_needs_exec` is 0, and the read port afterwards returns that index for the destination.
- R4: Any other instruction is not an idiom. This covers other opcodes (move-immediate 8'hC7 included), differing registers, and a mode other than 2'b11. Such an instruction has `out_needs_exec`=1 and takes the next value of a free counter, which starts at 8, counts up to NUM_PHYS-2 (14), then wraps to 8. Idioms do not advance the counter.
- R5: The destination architectural register is bits [5:3] for opcodes 8'h33 and 8'h2B, and bits [2:0] for every other opcode.
- R6: An idiom gives zero=1, sign=0, carry=0, overflow=0 with `out_flags_known`=1. A non-idiom gives `out_flags_known`=0 and all four flags 0.
- R7: After reset `out_valid` is 0, `in_ready` is 1, and the read port returns i for architectural register i.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady and neither the rename table nor the counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_opcode | input | 8 | Opcode byte |
| in_regbyte | input | 8 | Mode and register byte |
| out_valid | output | 1 | Renamed result present |
| out_ready | input | 1 | Consumer takes result |
| out_is_idiom | output | 1 | Zeroing idiom recognised |
| out_needs_exec | output | 1 | Instruction needs an execution slot |
| out_arch_dst | output | 3 | Destination architectural register |
| out_phys_dst | output | PW | Physical register assigned |
| out_flags_known | output | 1 | Flags resolved at rename |
| out_flag_z | output | 1 | Zero flag |
| out_flag_s | output | 1 | Sign flag |
| out_flag_c | output | 1 | Carry flag |
| out_flag_o | output | 1 | Overflow flag |
| rd_arch | input | 3 | Read-port architectural register |
| rd_phys | output | PW | Current mapping of `rd_arch` |

## Verification
A rename table entry written wrongly shows up on the read port in the cycle right after the accepting edge. It also shows up in the physical number carried with the same instruction on the output. A free counter that steps on an idiom, or misses its wrap, shows a wrong physical number on the next non-idiom instruction. The bench therefore follows each step with a read-back and runs the counter all the way through its wrap. A stall that lets the table move shows up as a changed read-port value while the output is held.

// File: rtl/zr_pkg.sv
package zr_pkg;
   localparam logic [7:0] OP_XOR_TO_RM  = 8'h31;
   localparam logic [7:0] OP_XOR_TO_REG = 8'h33;
   localparam logic [7:0] OP_SUB_TO_RM  = 8'h29;
   localparam logic [7:0] OP_SUB_TO_REG = 8'h2B;
   localparam logic [1:0] MODE_REG_DIRECT = 2'b11;
   localparam int ARCH_REGS = 8;
   localparam int ARCH_W    = 3;

   typedef struct packed {
      logic              idiom;
      logic [ARCH_W-1:0] dst;
   } dec_t;
endpackage

// File: rtl/zr_decode.sv
module zr_decode
   import zr_pkg::*;
#(
   parameter bit ENABLE_SUB = 1'b1
) (
   input  logic [7:0] opcode,
   input  logic [7:0] regbyte,
   output dec_t       dec
);
   logic reg_mode, same_reg, xor_hit, sub_hit, dst_in_reg_field;

   assign reg_mode = (regbyte[7:6] == MODE_REG_DIRECT);
   assign same_reg = (regbyte[5:3] == regbyte[2:0]);
   assign xor_hit  = (opcode == OP_XOR_TO_RM) || (opcode == OP_XOR_TO_REG);

   generate
      if (ENABLE_SUB) begin : g_sub_on
         assign sub_hit = (opcode == OP_SUB_TO_RM) || (opcode == OP_SUB_TO_REG);
      end else begin : g_sub_off
         assign sub_hit = 1'b0;
      end
   endgenerate

   assign dst_in_reg_field = (opcode == OP_XOR_TO_REG) || (opcode == OP_SUB_TO_REG);

   always_comb begin
      dec.idiom = reg_mode && same_reg && (xor_hit || sub_hit);
      dec.dst   = dst_in_reg_field ? regbyte[5:3] : regbyte[2:0];
   end
endmodule

// File: rtl/zr_free_ctr.sv
module zr_free_ctr #(
   parameter int PW    = 4,
   parameter int FIRST = 8,
   parameter int LAST  = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   output logic [PW-1:0] cur
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cur <= PW'(FIRST);
      else if (take)
         cur <= (cur == PW'(LAST)) ? PW'(FIRST) : cur + PW'(1);
   end
endmodule

// File: rtl/zr_map_table.sv
module zr_map_table #(
   parameter int NARCH = 8,
   parameter int AW    = 3,
   parameter int PW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_arch,
   input  logic [PW-1:0] wr_phys,
   input  logic [AW-1:0] rd_arch,
   output logic [PW-1:0] rd_phys
);
   logic [PW-1:0] entry [NARCH];

   generate
      for (genvar i = 0; i < NARCH; i++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n)
               entry[i] <= PW'(i);
            else if (wr_en && (wr_arch == AW'(i)))
               entry[i] <= wr_phys;
         end
      end
   endgenerate

   assign rd_phys = entry[rd_arch];
endmodule

// File: rtl/zidiom_rename.sv
module zidiom_rename
   import zr_pkg::*;
#(
   parameter int NUM_PHYS   = 16,
   parameter bit ENABLE_SUB = 1'b1,
   localparam int PW        = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_opcode,
   input  logic [7:0]        in_regbyte,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_is_idiom,
   output logic              out_needs_exec,
   output logic [ARCH_W-1:0] out_arch_dst,
   output logic [PW-1:0]     out_phys_dst,
   output logic              out_flags_known,
   output logic              out_flag_z,
   output logic              out_flag_s,
   output logic              out_flag_c,
   output logic              out_flag_o,
   input  logic [ARCH_W-1:0] rd_arch,
   output logic [PW-1:0]     rd_phys
);
   localparam int ZERO_PREG  = NUM_PHYS - 1;
   localparam int FIRST_FREE = ARCH_REGS;
   localparam int LAST_FREE  = NUM_PHYS - 2;

   generate
      if (NUM_PHYS < ARCH_REGS + 2) begin : g_bad_size
         $error("NUM_PHYS must leave room for the zero register and one free entry");
      end
   endgenerate

   dec_t          dec;
   logic          accept;
   logic [PW-1:0] fresh;
   logic [PW-1:0] new_phys;

   zr_decode #(.ENABLE_SUB(ENABLE_SUB)) u_dec (
      .opcode (in_opcode),
      .regbyte(in_regbyte),
      .dec    (dec)
   );

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;
   assign new_phys = dec.idiom ? PW'(ZERO_PREG) : fresh;

   zr_free_ctr #(.PW(PW), .FIRST(FIRST_FREE), .LAST(LAST_FREE)) u_free (
      .clk  (clk),
      .rst_n(rst_n),
      .take (accept && !dec.idiom),
      .cur  (fresh)
   );

   zr_map_table #(.NARCH(ARCH_REGS), .AW(ARCH_W), .PW(PW)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (accept),
      .wr_arch(dec.dst),
      .wr_phys(new_phys),
      .rd_arch(rd_arch),
      .rd_phys(rd_phys)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid       <= 1'b0;
         out_is_idiom    <= 1'b0;
         out_needs_exec  <= 1'b0;
         out_arch_dst    <= '0;
         out_phys_dst    <= '0;
         out_flags_known <= 1'b0;
         out_flag_z      <= 1'b0;
         out_flag_s      <= 1'b0;
         out_flag_c      <= 1'b0;
         out_flag_o      <= 1'b0;
      end else if (accept) begin
         out_valid       <= 1'b1;
         out_is_idiom    <= dec.idiom;
         out_needs_exec  <= !dec.idiom;
         out_arch_dst    <= dec.dst;
         out_phys_dst    <= new_phys;
         out_flags_known <= dec.idiom;
         out_flag_z      <= dec.idiom;
         out_flag_s      <= 1'b0;
         out_flag_c      <= 1'b0;
         out_flag_o      <= 1'b0;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/zr_checker.sv
module zr_checker #(
   parameter int NUM_PHYS = 16,
   localparam int PW      = $clog2(NUM_PHYS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic [7:0]    in_opcode,
   input logic [7:0]    in_regbyte,
   input logic          out_valid,
   input logic          out_ready,
   input logic          out_is_idiom,
   input logic          out_needs_exec,
   input logic [PW-1:0] out_phys_dst,
   input logic          out_flags_known,
   input logic          out_flag_z,
   input logic          out_flag_s,
   input logic          out_flag_c,
   input logic          out_flag_o
);
   logic take_same_reg;
   assign take_same_reg = in_valid && in_ready && (in_regbyte[7:6] == 2'b11)
                          && (in_regbyte[5:3] == in_regbyte[2:0]);

   AST_XOR_SAME_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      take_same_reg && (in_opcode == 8'h31 || in_opcode == 8'h33) |=> out_is_idiom); // R1
   AST_SUB_SAME_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      take_same_reg && (in_opcode == 8'h29 || in_opcode == 8'h2B) |=> out_is_idiom); // R2
   AST_IDIOM_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_is_idiom |-> out_phys_dst == PW'(NUM_PHYS - 1) && !out_needs_exec); // R3
   AST_FRESH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_needs_exec |-> out_phys_dst >= PW'(8) && out_phys_dst <= PW'(NUM_PHYS - 2)); // R4
   AST_IDIOM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_is_idiom |-> out_flags_known && out_flag_z && !out_flag_s && !out_flag_c && !out_flag_o); // R6
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_phys_dst) && $stable(out_is_idiom)); // R8
endmodule

bind zidiom_rename zr_checker #(.NUM_PHYS(NUM_PHYS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_opcode(in_opcode), .in_regbyte(in_regbyte), .out_valid(out_valid),
   .out_ready(out_ready), .out_is_idiom(out_is_idiom), .out_needs_exec(out_needs_exec),
   .out_phys_dst(out_phys_dst), .out_flags_known(out_flags_known),
   .out_flag_z(out_flag_z), .out_flag_s(out_flag_s), .out_flag_c(out_flag_c),
   .out_flag_o(out_flag_o)
);

// File: tb/zidiom_rename_bench.sv
module zidiom_rename_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_opcode = 8'h00;
   logic [7:0] in_regbyte = 8'h00;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic       out_is_idiom, out_needs_exec, out_flags_known;
   logic       out_flag_z, out_flag_s, out_flag_c, out_flag_o;
   logic [2:0] out_arch_dst;
   logic [3:0] out_phys_dst;
   logic [2:0] rd_arch = 3'd0;
   logic [3:0] rd_phys;
   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   zidiom_rename u_zidiom_rename (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_opcode(in_opcode), .in_regbyte(in_regbyte), .out_valid(out_valid),
      .out_ready(out_ready), .out_is_idiom(out_is_idiom), .out_needs_exec(out_needs_exec),
      .out_arch_dst(out_arch_dst), .out_phys_dst(out_phys_dst),
      .out_flags_known(out_flags_known), .out_flag_z(out_flag_z), .out_flag_s(out_flag_s),
      .out_flag_c(out_flag_c), .out_flag_o(out_flag_o), .rd_arch(rd_arch), .rd_phys(rd_phys)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // {opcode, regbyte, idiom, phys, dst}
   localparam logic [23:0] VEC [13] = '{
      {8'h31, 8'hC0, 1'b1, 4'd15, 3'd0},  // R1 xor r0,r0
      {8'h29, 8'hDB, 1'b1, 4'd15, 3'd3},  // R2 sub r3,r3
      {8'h33, 8'hF6, 1'b1, 4'd15, 3'd6},  // R1
      {8'h2B, 8'hFF, 1'b1, 4'd15, 3'd7},  // R2
      {8'h31, 8'hC1, 1'b0, 4'd8,  3'd1},  // R4 differing regs, R5 rm field
      {8'h33, 8'hC1, 1'b0, 4'd9,  3'd0},  // R5 reg field
      {8'h01, 8'hC9, 1'b0, 4'd10, 3'd1},  // R4 other opcode
      {8'h31, 8'h12, 1'b0, 4'd11, 3'd2},  // R4 memory mode
      {8'h2B, 8'h5B, 1'b0, 4'd12, 3'd3},  // R4 mode 01, R5
      {8'hC7, 8'hC0, 1'b0, 4'd13, 3'd0},  // R4 move-immediate
      {8'h29, 8'hD1, 1'b0, 4'd14, 3'd1},  // R4 last free
      {8'h31, 8'hE4, 1'b1, 4'd15, 3'd4},  // R3 idiom leaves counter
      {8'h29, 8'hC2, 1'b0, 4'd8,  3'd2}   // R4 wrap
   };

   initial begin
      #2_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 out_valid", out_valid, 0);
      chk("R7 in_ready", in_ready, 1);
      for (int i = 0; i < 8; i++) begin
         rd_arch = 3'(i);
         #1 chk("R7 identity map", rd_phys, i);
      end

      for (int v = 0; v < 13; v++) begin
         logic [23:0] e;
         e = VEC[v];
         @(negedge clk);
         in_valid = 1'b1;
         in_opcode = e[23:16];
         in_regbyte = e[15:8];
         @(negedge clk);
         in_valid = 1'b0;
         chk("R8 out_valid", out_valid, 1);
         chk(e[7] ? "R1/R2 idiom" : "R4 not idiom", out_is_idiom, e[7]);
         chk(e[7] ? "R3 phys" : "R4 phys", out_phys_dst, e[6:3]);
         chk(e[7] ? "R3 needs_exec" : "R4 needs_exec", out_needs_exec, !e[7]);
         chk("R5 arch dst", out_arch_dst, e[2:0]);
         chk("R6 flags_known", out_flags_known, e[7]);
         chk("R6 flag z", out_flag_z, e[7]);
         chk("R6 flags s/c/o", {out_flag_s, out_flag_c, out_flag_o}, 0);
         rd_arch = e[2:0];
         #1 chk("R3 table read-back", rd_phys, e[6:3]);
      end

      // R8 stall: idiom on r5 held, second instruction waits
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1;
      in_opcode = 8'h31;
      in_regbyte = 8'hED;
      @(negedge clk);
      in_opcode = 8'h01;
      in_regbyte = 8'hC0;
      for (int k = 0; k < 2; k++) begin
         chk("R8 in_ready low", in_ready, 0);
         chk("R8 held valid", out_valid, 1);
         chk("R8 held phys", out_phys_dst, 15);
         chk("R8 held dst", out_arch_dst, 5);
         rd_arch = 3'd0;
         #1 chk("R8 table frozen", rd_phys, 13);
         @(negedge clk);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 next taken", out_valid, 1);
      chk("R4 after stall phys", out_phys_dst, 9);
      chk("R5 after stall dst", out_arch_dst, 0);
      rd_arch = 3'd0;
      #1 chk("R8 table updated", rd_phys, 9);
      rd_arch = 3'd5;
      #1 chk("R3 r5 zero", rd_phys, 15);
      @(negedge clk);
      chk("R8 drains", out_valid, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule